// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block reads a run of bytes from a four-wire serial EEPROM by toggling its control lines one step at a time: two access-gate lines, a serial clock, a data line towards the memory and a data line back from it. A request carries a 16-bit byte address, a base offset that is added to it, and a byte count. The sequencer opens access, sends the read command and the summed address, clocks in the requested bytes and closes access again.

Each received byte appears on a parallel bus together with a single-cycle strobe. The memory has no chip select. Access is opened by raising the high-side gate and then dropping the low-side gate. It is closed by doing the reverse steps in the reverse order. Every line update is held for a parameterised number of system clocks so that the memory's setup and hold times are met.

A request is refused without touching the memory lines if the memory is reported missing or if the base offset does not fit in 16 bits. A one-cycle done pulse ends every request, and an error flag marks the refused ones.

Top module: `ee_rd_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the lines read access_hi=0, access_lo=1, ser_clk=0, and busy_o=0.
- R2: Opening access raises access_hi while access_lo is still 1. access_lo falls only in a later phase. The two gate lines are never both 0.
- R3: Closing access raises access_lo first and drops access_hi in the following phase. busy_o falls in the cycle where done_o pulses with err_o=0.
- R4: The header is 24 bits, sent most significant bit first: command byte 0x03, then the address high byte, then the address low byte. ser_do is set while ser_clk is low and is held steady while ser_clk is high.
- R5: The address sent is (addr_i + base_i[15:0]) mod 65536.
- R6: Read data is sampled at the end of each clock-high phase and shifted into the low end of the byte, so bytes arrive most significant bit first.
- R7: Each received byte is presented on byte_o with a byte_valid_o pulse lasting exactly one cycle. Exactly count_i bytes are delivered, from consecutive addresses that wrap modulo 65536.
- R8: A count of 0 still sends the header and closes access, and delivers no byte.
- R9: If present_i=0, absent_i=1 or base_i>0xFFFF, the request is refused. done_o and err_o pulse together for one cycle, busy_o stays 0, and the gate lines do not move.
- R10: Every ser_clk high phase lasts exactly HALF_PERIOD system clocks.
- R11: A start_i pulse while busy_o=1 is ignored. The running transfer completes unchanged and ends with a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken while idle |
| addr_i | input | 16 | Byte address within the memory region |
| base_i | input | BASE_W | Base offset added to addr_i |
| count_i | input | CNT_W | Number of bytes to read |
| present_i | input | 1 | Memory reported present |
| absent_i | input | 1 | Memory reported missing |
| ee_acc_hi_o | output | 1 | High-side access gate |
| ee_acc_lo_o | output | 1 | Low-side access gate |
| ee_clk_o | output | 1 | Serial clock to memory |
| ee_do_o | output | 1 | Serial data to memory |
| ee_di_i | input | 1 | Serial data from memory |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request refused, valid with done_o |

## Verification
The hardest case to reach is an address sum that wraps past 0xFFFF in the middle of a multi-byte read, because the wrap only shows up in the memory's internal address counter. The bench's memory model derives each byte from its address and keeps a 16-bit pointer that wraps. One stimulus row sums to 0x0001 and another starts at 0xFFFF, so any wrong carry or truncation produces wrong data. A second start pulse is injected mid-transfer to show that a busy request is not disturbed.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned HDR_W  = 24;
  localparam logic [7:0]  CMD_RD = 8'h03;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_HI,
    S_EN_LO,
    S_O_SET,
    S_O_HI,
    S_O_LO,
    S_I_HI,
    S_I_LO,
    S_DIS_LO,
    S_DIS_HI
  } ee_state_e;
endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
  parameter int unsigned HALF_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic end_o
);
  localparam int unsigned CW = $clog2(HALF_PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || end_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_shift_unit.sv
module ee_shift_unit
  import ee_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             tx_shift_i,
  input  logic             rx_shift_i,
  input  logic             di_i,
  output logic             tx_bit_o,
  output logic [7:0]       rx_next_o
);
  logic [HDR_W-1:0] tx_q;
  logic [7:0]       rx_q;

  assign tx_bit_o  = tx_q[HDR_W-1];
  assign rx_next_o = {rx_q[6:0], di_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)          tx_q <= hdr_i;
      else if (tx_shift_i) tx_q <= {tx_q[HDR_W-2:0], 1'b0};
      if (rx_shift_i)      rx_q <= rx_next_o;
    end
  end
endmodule

// File: rtl/ee_rd_seq.sv
module ee_rd_seq
  import ee_rd_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 4,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned BASE_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              present_i,
  input  logic              absent_i,
  output logic              ee_acc_hi_o,
  output logic              ee_acc_lo_o,
  output logic              ee_clk_o,
  output logic              ee_do_o,
  input  logic              ee_di_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [4:0] HDR_LAST = 5'(HDR_W - 1);

  ee_state_e         state_q;
  logic [4:0]        bit_q;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        byte_q;
  logic              valid_q, done_q, err_q;
  logic              pe, fault, load, tx_shift, rx_shift, tx_bit;
  logic [ADDR_W-1:0] dev_addr;
  logic [7:0]        rx_next;

  assign dev_addr = addr_i + base_i[ADDR_W-1:0];
  assign fault    = !present_i || absent_i || ((base_i >> ADDR_W) != '0);
  assign load     = (state_q == S_IDLE) && start_i && !fault;
  assign tx_shift = (state_q == S_O_LO) && pe;
  assign rx_shift = (state_q == S_I_HI) && pe;

  ee_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != S_IDLE),
    .end_o (pe)
  );

  ee_shift_unit u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .hdr_i     ({CMD_RD, dev_addr}),
    .tx_shift_i(tx_shift),
    .rx_shift_i(rx_shift),
    .di_i      (ee_di_i),
    .tx_bit_o  (tx_bit),
    .rx_next_o (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bit_q   <= '0;
      left_q  <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          if (fault) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            left_q  <= count_i;
            bit_q   <= '0;
            state_q <= S_EN_HI;
          end
        end
        S_EN_HI: if (pe) state_q <= S_EN_LO;
        S_EN_LO: if (pe) state_q <= S_O_SET;
        S_O_SET: if (pe) state_q <= S_O_HI;
        S_O_HI:  if (pe) state_q <= S_O_LO;
        S_O_LO: if (pe) begin
          if (bit_q == HDR_LAST) begin
            bit_q   <= '0;
            state_q <= (left_q == '0) ? S_DIS_LO : S_I_HI;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= S_O_SET;
          end
        end
        S_I_HI: if (pe) begin
          if (bit_q == 5'd7) begin
            byte_q  <= rx_next;
            valid_q <= 1'b1;
          end
          state_q <= S_I_LO;
        end
        S_I_LO: if (pe) begin
          if (bit_q == 5'd7) begin
            bit_q   <= '0;
            left_q  <= left_q - 1'b1;
            state_q <= (left_q == CNT_W'(1)) ? S_DIS_LO : S_I_HI;
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= S_I_HI;
          end
        end
        S_DIS_LO: if (pe) state_q <= S_DIS_HI;
        S_DIS_HI: if (pe) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ee_acc_hi_o  = (state_q != S_IDLE) && (state_q != S_DIS_HI);
  assign ee_acc_lo_o  = (state_q == S_IDLE) || (state_q == S_EN_HI) ||
                        (state_q == S_DIS_LO) || (state_q == S_DIS_HI);
  assign ee_clk_o     = (state_q == S_O_HI) || (state_q == S_I_HI);
  assign ee_do_o      = ((state_q == S_O_SET) || (state_q == S_O_HI) ||
                         (state_q == S_O_LO)) && tx_bit;
  assign byte_o       = byte_q;
  assign byte_valid_o = valid_q;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/ee_rd_seq_chk.sv
module ee_rd_seq_chk #(
  parameter int unsigned HALF_PERIOD = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ee_acc_hi_o,
  input logic ee_acc_lo_o,
  input logic ee_clk_o,
  input logic ee_do_o,
  input logic byte_valid_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_cnt <= '0;
    else if (ee_clk_o) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  // R2
  gates_never_both_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_acc_hi_o || ee_acc_lo_o);

  // R2
  clk_only_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_clk_o |-> (ee_acc_hi_o && !ee_acc_lo_o));

  // R4
  do_steady_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_clk_o && $past(ee_clk_o)) |-> $stable(ee_do_o));

  // R3
  busy_fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && !err_o));

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R9
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !busy_o && !ee_acc_hi_o && ee_acc_lo_o));

  // R10
  clk_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ee_clk_o) |-> (hi_cnt == 16'(HALF_PERIOD)));

  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ee_acc_hi_o && ee_acc_lo_o && !ee_clk_o));
endmodule

bind ee_rd_seq ee_rd_seq_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ee_acc_hi_o (ee_acc_hi_o),
  .ee_acc_lo_o (ee_acc_lo_o),
  .ee_clk_o    (ee_clk_o),
  .ee_do_o     (ee_do_o),
  .byte_valid_o(byte_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/ee_rd_seq_tb.sv
module ee_rd_seq_tb;
  localparam int HP = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [31:0] base_i = '0;
  logic [7:0]  count_i = '0;
  logic        present_i = 1'b1;
  logic        absent_i = 1'b0;
  logic        ee_acc_hi_o, ee_acc_lo_o, ee_clk_o, ee_do_o;
  logic        ee_di_i;
  logic [7:0]  byte_o;
  logic        byte_valid_o, busy_o, done_o, err_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  ee_rd_seq #(.HALF_PERIOD(HP)) u_dut (.*);

  function automatic logic [7:0] mem_b(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hC3;
  endfunction

  // memory model
  logic [23:0] hdr_sh;
  int          hdr_n;
  logic        rd_mode, seen_rise;
  logic [15:0] ptr;
  int          rd_k;
  logic [7:0]  cap_cmd;
  logic [15:0] cap_addr;

  always_comb ee_di_i = mem_b(ptr + 16'(rd_k / 8))[7 - (rd_k % 8)];

  always @(posedge ee_acc_hi_o) begin
    hdr_n = 0; rd_mode = 1'b0; seen_rise = 1'b0; rd_k = 0; ptr = '0;
  end
  always @(posedge ee_clk_o) begin
    if (!rd_mode) begin
      hdr_sh = {hdr_sh[22:0], ee_do_o};
      hdr_n++;
      if (hdr_n == 24) begin
        rd_mode = 1'b1;
        cap_cmd = hdr_sh[23:16];
        cap_addr = hdr_sh[15:0];
        ptr = hdr_sh[15:0];
      end
    end else seen_rise = 1'b1;
  end
  always @(negedge ee_clk_o) if (rd_mode && seen_rise) rd_k++;

  // port monitors
  logic [7:0] got [16];
  int got_n = 0, done_n = 0, hi_rises = 0, both_low = 0, hi_run = 0, bad_len = 0;
  logic hi_prev = 1'b0;
  always @(negedge clk_i) if (rst_ni) begin
    if (byte_valid_o) begin
      if (got_n < 16) got[got_n] = byte_o;
      got_n++;
    end
    if (done_o) done_n++;
    if (ee_acc_hi_o && !hi_prev) hi_rises++;
    hi_prev = ee_acc_hi_o;
    if (!ee_acc_hi_o && !ee_acc_lo_o) both_low++;
    if (ee_clk_o) hi_run++;
    else if (hi_run != 0) begin
      if (hi_run != HP) bad_len++;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {addr16, base32, count8, present, absent, expect_err, pad5}
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    {16'h0000, 32'h0000_0000, 8'd3, 1'b1, 1'b0, 1'b0, 5'd0},
    {16'h1234, 32'h0000_0100, 8'd2, 1'b1, 1'b0, 1'b0, 5'd0},
    {16'hFFFE, 32'h0000_0003, 8'd4, 1'b1, 1'b0, 1'b0, 5'd0},
    {16'h00AA, 32'h0000_0000, 8'd0, 1'b1, 1'b0, 1'b0, 5'd0},
    {16'h0010, 32'h0001_0000, 8'd2, 1'b1, 1'b0, 1'b1, 5'd0},
    {16'h0020, 32'h0000_0000, 8'd2, 1'b0, 1'b0, 1'b1, 5'd0},
    {16'h0030, 32'h0000_0000, 8'd2, 1'b1, 1'b1, 1'b1, 5'd0},
    {16'h8000, 32'h0000_7FFF, 8'd5, 1'b1, 1'b0, 1'b0, 5'd0}
  };

  bit timed_out;
  int seen_busy;

  task automatic run(input logic [15:0] a, input logic [31:0] b, input logic [7:0] c,
                     input logic p, input logic ab, input bit extra_start);
    int n;
    logic got_err;
    got_n = 0; done_n = 0; timed_out = 0; seen_busy = 0; got_err = 0;
    @(negedge clk_i);
    addr_i = a; base_i = b; count_i = c; present_i = p; absent_i = ab; start_i = 1'b1;
    n = 0;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (busy_o) seen_busy = 1;
      if (extra_start && n == 60) begin
        addr_i = 16'h4444; count_i = 8'd1; start_i = 1'b1;
      end
      if (done_o) break;
      n++;
      if (n > 20000) begin timed_out = 1; break; end
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    logic [15:0] ea;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!ee_acc_hi_o && ee_acc_lo_o && !ee_clk_o && !busy_o && !done_o, "R1",
        {ee_acc_hi_o, ee_acc_lo_o, ee_clk_o, busy_o}, 4'b0100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!ee_acc_hi_o && ee_acc_lo_o && !busy_o, "R1",
        {ee_acc_hi_o, ee_acc_lo_o, busy_o}, 3'b010);

    for (int i = 0; i < NV; i++) begin
      automatic logic [63:0] v = VEC[i];
      automatic int rises0 = hi_rises;
      run(v[63:48], v[47:16], v[15:8], v[7], v[6], 1'b0);
      chk(!timed_out, "R3", timed_out, 0);
      chk(done_n == 1, "R3", done_n, 1);
      if (v[5]) begin
        // R9 refused request leaves lines untouched
        chk(hi_rises == rises0 && seen_busy == 0, "R9", hi_rises - rises0, 0);
        chk(got_n == 0, "R9", got_n, 0);
      end else begin
        ea = v[63:48] + v[31:16];
        // R4 header command, R5 summed address
        chk(cap_cmd == 8'h03, "R4", cap_cmd, 8'h03);
        chk(cap_addr == ea, "R5", cap_addr, ea);
        // R7 exact byte count; R8 when zero
        chk(got_n == int'(v[15:8]), v[15:8] == 0 ? "R8" : "R7", got_n, v[15:8]);
        for (int k = 0; k < got_n && k < 16; k++)
          chk(got[k] == mem_b(ea + 16'(k)), "R6", got[k], mem_b(ea + 16'(k)));
        chk(!ee_acc_hi_o && ee_acc_lo_o, "R3", {ee_acc_hi_o, ee_acc_lo_o}, 2'b01);
      end
    end

    // R11 start while busy is ignored
    run(16'h0100, 32'h0, 8'd2, 1'b1, 1'b0, 1'b1);
    chk(done_n == 1, "R11", done_n, 1);
    chk(cap_addr == 16'h0100, "R11", cap_addr, 16'h0100);
    chk(got_n == 2, "R11", got_n, 2);
    if (got_n == 2) chk(got[1] == mem_b(16'h0101), "R11", got[1], mem_b(16'h0101));

    // R2 gate ordering, R10 clock-high width
    chk(both_low == 0, "R2", both_low, 0);
    chk(bad_len == 0, "R10", bad_len, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule